// File: doc/BRIEF.md
# Programmable Periodic Tick Interrupt

This block derives a periodic tick from a 32.768 kHz time base. A free-running 15-bit divider counts clock cycles. A 3-bit period code selects which power-of-two fraction of one second separates the ticks. Each tick is a pulse one cycle wide.

Every tick sets a sticky status flag. Software clears the flag by writing 1 to it. An enable bit gates the flag onto an interrupt line. When the system is in a low-power state, the same gated condition also drives a wake-up request.

Software programs the period code, the enable bit and the flag clear through simple write strobes. The flag is visible on a port so that software can poll it.

Top module: `tick_timer`

## Requirements
- R1: Period codes 0 to 6 give a tick every 32768 >> code cycles of the time base, which is 1, 1/2, 1/4, 1/8, 1/16, 1/32 and 1/64 second.
- R2: Period code 7 gives a tick every 256 cycles, which is 1/128 second.
- R3: The tick output is high for exactly one cycle per period. The tick is taken from the free-running divider when all of the divider's low (15 - code) bits are 1.
- R4: The tick flag goes to 1 on the cycle after a tick and keeps that value until it is cleared.
- R5: A flag write with data 1 clears the flag on the next cycle. A flag write with data 0 leaves the flag unchanged.
- R6: If a clearing flag write and a tick fall in the same cycle, the flag remains 1.
- R7: The interrupt output is high exactly when the flag is 1 and the enable bit is 1.
- R8: The wake output is high exactly when the interrupt condition holds and the low-power input is 1.
- R9: A period write whose code differs from the current code resets the divider to zero, so the first new tick comes one full new period after the write edge. A write of the same code does not disturb the tick schedule.
- R10: After reset the period code is 0, and the enable bit, the flag, the interrupt and the wake request are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 32.768 kHz time-base clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_wr | input | 1 | Write strobe for the period code |
| sel_wdata | input | 3 | New period code |
| en_wr | input | 1 | Write strobe for the enable bit |
| en_wdata | input | 1 | New enable value |
| flag_wr | input | 1 | Write strobe for the flag (write-1-to-clear) |
| flag_wdata | input | 1 | Flag write data; 1 clears the flag |
| low_power | input | 1 | High while the system is idle or powered down |
| tick | output | 1 | Single-cycle tick pulse |
| tick_flag | output | 1 | Sticky tick flag |
| irq | output | 1 | Interrupt request |
| wake | output | 1 | Wake-up request |

## Verification
A period write on edge E produces ticks combinationally from the divider in the cycles after edges E+P-1, E+2P-1 and so on, where P is the new period. The driver pushes these edge numbers into a queue. The monitor samples at falling edges and compares each tick it sees against the head of the queue, so both an early tick and a late tick show up as a mismatch.

The flag is registered, so it is checked one cycle after the tick or the write. The interrupt and wake outputs are combinational from the registers and the low-power input, so they are checked at the falling edge that follows the change. The same-cycle tick-and-clear case is driven on the exact cycle in which the tick is observed.

// File: rtl/tick_timer.sv
module tick_timer #(
  parameter int DIV_W = 15,
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel_wr,
  input  logic [SEL_W-1:0] sel_wdata,
  input  logic             en_wr,
  input  logic             en_wdata,
  input  logic             flag_wr,
  input  logic             flag_wdata,
  input  logic             low_power,
  output logic             tick,
  output logic             tick_flag,
  output logic             irq,
  output logic             wake
);

  localparam logic [DIV_W-1:0] FULL = '1;

  logic [SEL_W-1:0] sel_q;
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] mask;
  logic             en_q;
  logic             flag_q;
  logic             restart;
  logic             clr;

  assign restart = sel_wr && (sel_wdata != sel_q);
  assign clr     = flag_wr && flag_wdata;
  assign mask    = FULL >> sel_q;
  assign tick    = ((cnt_q & mask) == mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0;
      cnt_q <= '0;
    end else if (restart) begin
      sel_q <= sel_wdata;
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      if (en_wr) en_q <= en_wdata;
      if (tick)     flag_q <= 1'b1;
      else if (clr) flag_q <= 1'b0;
    end
  end

  assign tick_flag = flag_q;
  assign irq       = flag_q & en_q;
  assign wake      = irq & low_power;

  p_tick_sets_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> tick_flag);

  p_clear_works_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !tick) |=> !tick_flag);

  p_flag_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_flag && !clr) |=> tick_flag);

  p_tick_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);

  p_restart_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !tick);

  p_wake_needs_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wake |-> (irq && low_power));

  p_irq_needs_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> tick_flag);

endmodule

// File: tb/tb_tick_timer.sv
module tb_tick_timer;
  logic clk = 0, rst_n = 0;
  logic sel_wr = 0, en_wr = 0, en_wdata = 0, flag_wr = 0, flag_wdata = 0, low_power = 0;
  logic [2:0] sel_wdata = 0;
  logic tick, tick_flag, irq, wake;
  int cyc = 0, total = 0, bad = 0, last_exp = 0;
  bit done = 0;
  int expq[$];

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  tick_timer dut (.clk, .rst_n, .sel_wr, .sel_wdata, .en_wr, .en_wdata, .flag_wr,
    .flag_wdata, .low_power, .tick, .tick_flag, .irq, .wake);

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d cyc=%0d", req, act, exp, cyc);
    end
  endtask

  always @(negedge clk) if (rst_n && tick) begin
    if (expq.size() == 0) chk("R1/R2/R3 unexpected tick", cyc, -1);
    else chk("R1/R2/R3/R9 tick time", cyc, expq.pop_front());
  end

  task automatic drain;
    while (cyc < last_exp + 2) @(negedge clk);
    chk("R3 no missing tick", expq.size(), 0);
  endtask

  task automatic set_period(input logic [2:0] code, input int n);
    int e, p;
    @(negedge clk);
    sel_wr = 1; sel_wdata = code; e = cyc + 1; p = 32768 >> code;
    @(negedge clk);
    sel_wr = 0;
    for (int j = 1; j <= n; j++) expq.push_back(e + j * p - 1);
    last_exp = e + n * p - 1;
    drain();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R10 flag", tick_flag, 0); chk("R10 irq", irq, 0);
    chk("R10 wake", wake, 0); chk("R10 tick", tick, 0);
    rst_n = 1;
    set_period(7, 4);                       // R2
    chk("R4 flag set", tick_flag, 1);
    chk("R7 irq off when disabled", irq, 0);
    en_wr = 1; en_wdata = 1; @(negedge clk); en_wr = 0;
    chk("R7 irq on", irq, 1); chk("R8 wake off", wake, 0);
    low_power = 1; @(negedge clk);
    chk("R8 wake on", wake, 1);
    flag_wr = 1; flag_wdata = 0; @(negedge clk); flag_wr = 0;
    chk("R5 write 0 ignored", tick_flag, 1);
    flag_wr = 1; flag_wdata = 1; @(negedge clk); flag_wr = 0;
    chk("R5 write 1 clears", tick_flag, 0);
    chk("R7 irq follows flag", irq, 0); chk("R8 wake follows", wake, 0);
    last_exp = last_exp + 256; expq.push_back(last_exp);
    while (!tick) @(negedge clk);
    flag_wr = 1; flag_wdata = 1; @(negedge clk); flag_wr = 0;
    chk("R6 tick beats clear", tick_flag, 1);
    flag_wr = 1; @(negedge clk); flag_wr = 0;
    chk("R5 clear after R6", tick_flag, 0);
    low_power = 0;
    for (int c = 6; c >= 1; c--) set_period(3'(c), 2);   // R1
    // R9: same-code rewrite keeps the schedule
    last_exp = last_exp + 16384; expq.push_back(last_exp);
    repeat (100) @(negedge clk);
    sel_wr = 1; sel_wdata = 1; @(negedge clk); sel_wr = 0;
    drain();
    set_period(0, 1);                       // R1 one second
    chk("R4 flag after slow tick", tick_flag, 1);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule